// File: doc/BRIEF.md
# Synchronous Transfer Window Counter

This block paces the sending side of a synchronous parallel data phase. The far end holds a small receive buffer. Each acknowledge it returns means that one buffer entry was drained. It does not confirm that a byte arrived. The sender therefore runs ahead of the acknowledges. It counts how many entries are still in flight and issues a new strobe only while that count is below the agreed window. The window is 8 entries or 16 entries, where one entry is a byte on a narrow bus or a 16-bit word on a wide bus.

A transfer begins with a start pulse that carries a length. While upstream data is offered, the block emits one strobe per entry. Successive strobes are at least a programmed number of clocks apart, which stands in for the rate agreed before the data phase. Once every entry is sent and the receiver has drained them all, the block raises done. An acknowledge that arrives when nothing is in flight is a protocol fault. It is latched as a sticky error and never wraps the counter.

The sequencer has four states:
- IDLE: state after reset.
- SEND: strobes are issued.
- DRAIN: all entries are sent and the block waits for the count to reach zero.
- FIN: done is shown.

The transitions are:
- IDLE or FIN to SEND: start with a non-zero length.
- IDLE or FIN to DRAIN: start with a zero length.
- SEND to DRAIN: the strobe that sends the last entry.
- DRAIN to FIN: the outstanding count is zero.

Top module: `sxfer_window`

## Requirements
- R1: After reset the outstanding count is 0, and strobe, done, win_full and proto_err are all low. The effective window is 8 entries.
- R2: A strobe is issued only while the outstanding count is below the effective window. Each strobe adds one to the count and each accepted acknowledge removes one.
- R3: A strobe and an acknowledge in the same clock, with a non-zero count, leave the count unchanged.
- R4: An acknowledge while the count is 0 sets proto_err. proto_err then stays high until reset, and the count stays at 0 unless a strobe occurs in the same clock.
- R5: Two strobes are at least `period` clocks apart, where a period of 0 or 1 allows one strobe every clock. With data always offered and window space available, strobes are exactly `period` clocks apart.
- R6: win_sel=0 selects an 8-entry window and win_sel=1 selects a 16-entry window. win_sel is adopted at a clock edge only while the count is 0, so a change made with data outstanding has no effect until the buffer drains.
- R7: An accepted start with length N yields exactly N strobes and no more. A start made while a transfer is in SEND or DRAIN is ignored. A length of 0 yields no strobe.
- R8: done rises after all N entries are sent and the count has returned to 0. It stays high until the next accepted start.
- R9: win_full is high exactly when the outstanding count equals the effective window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a transfer; accepted only in IDLE or FIN |
| xfer_len | input | LEN_W | Number of entries to send, sampled with start |
| win_sel | input | 1 | Window size request: 0 = 8 entries, 1 = 16 entries |
| period | input | PER_W | Minimum clocks between strobes |
| send_req | input | 1 | Upstream has an entry ready |
| ack_in | input | 1 | Receiver drained one entry |
| strobe | output | 1 | Entry transfer strobe, one clock per entry |
| outstanding | output | CNT_W | Entries sent but not yet drained |
| win_full | output | 1 | Outstanding count equals the window |
| done | output | 1 | Transfer sent and fully drained |
| proto_err | output | 1 | Sticky: acknowledge received with nothing in flight |

## Verification
The bench builds the block with its default parameters. These are windows of 8 and 16 entries, a 16-bit length and an 8-bit period. With these values both window sizes can be filled to the limit, and the switch from the small window to the large one can be requested while the small window is full. Transfers of up to 40 entries are longer than either window, so they exercise steady operation with a full window, where strobes and acknowledges coincide. Periods from 0 to 4 cover both the clock-by-clock case and the paced strobe case.

// File: rtl/sxw_pkg.sv
package sxw_pkg;
    typedef enum logic [1:0] {
        ST_IDLE,
        ST_SEND,
        ST_DRAIN,
        ST_FIN
    } sxw_state_e;
endpackage

// File: rtl/sxw_pacer.sv
module sxw_pacer #(
    parameter int PER_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [PER_W-1:0] period,
    input  logic             fire,
    output logic             ready
);
    logic [PER_W-1:0] gap_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gap_q <= '0;
        end else if (fire) begin
            gap_q <= (period > PER_W'(1)) ? period - PER_W'(1) : '0;
        end else if (gap_q != '0) begin
            gap_q <= gap_q - PER_W'(1);
        end
    end

    assign ready = (gap_q == '0);

    // R5: no strobe while the spacing interval is still running
    a_r5_spacing: assert property (@(posedge clk) disable iff (!rst_n)
        !ready |-> !fire);
endmodule

// File: rtl/sxw_credit.sv
module sxw_credit #(
    parameter int WIN_SMALL = 8,
    parameter int WIN_LARGE = 16,
    parameter int CNT_W     = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             win_sel,
    input  logic             fire,
    input  logic             ack,
    output logic [CNT_W-1:0] cnt,
    output logic             space_ok,
    output logic             full,
    output logic             proto_err
);
    localparam logic [CNT_W-1:0] LIM_S = CNT_W'(WIN_SMALL);
    localparam logic [CNT_W-1:0] LIM_L = CNT_W'(WIN_LARGE);

    logic [CNT_W-1:0] cnt_q;
    logic             win_q;
    logic             err_q;
    logic [CNT_W-1:0] lim;
    logic             ack_ok;

    assign lim    = win_q ? LIM_L : LIM_S;
    assign ack_ok = ack && (cnt_q != '0);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            win_q <= 1'b0;
            err_q <= 1'b0;
        end else begin
            if (cnt_q == '0) begin
                win_q <= win_sel;
            end
            if (ack && cnt_q == '0) begin
                err_q <= 1'b1;
            end
            unique case ({fire, ack_ok})
                2'b10:   cnt_q <= cnt_q + CNT_W'(1);
                2'b01:   cnt_q <= cnt_q - CNT_W'(1);
                default: cnt_q <= cnt_q;
            endcase
        end
    end

    assign cnt       = cnt_q;
    assign space_ok  = (cnt_q < lim);
    assign full      = (cnt_q >= lim);
    assign proto_err = err_q;

    // R2: the count never exceeds the larger window
    a_r2_bound: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LIM_L);
    // R3: a strobe and a valid acknowledge cancel
    a_r3_balanced: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && ack && cnt_q != '0) |=> $stable(cnt_q));
    // R4: an acknowledge at zero does not wrap the counter and flags a fault
    a_r4_floor: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && !fire && cnt_q == '0) |=> (cnt_q == '0 && err_q));
    // R4: the fault flag is sticky
    a_r4_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        err_q |=> err_q);
    // R6: the window stays fixed while entries are in flight
    a_r6_win_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q != '0) |=> $stable(win_q));
endmodule

// File: rtl/sxw_seq.sv
module sxw_seq
    import sxw_pkg::*;
#(
    parameter int LEN_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [LEN_W-1:0] xfer_len,
    input  logic             send_req,
    input  logic             space_ok,
    input  logic             pace_ready,
    input  logic             cnt_zero,
    output logic             strobe,
    output logic             done
);
    sxw_state_e       state_q, state_d;
    logic [LEN_W-1:0] remain_q, remain_d;
    logic             accept;

    assign accept = start && (state_q == ST_IDLE || state_q == ST_FIN);

    always_comb begin
        state_d  = state_q;
        remain_d = remain_q;
        unique case (state_q)
            ST_IDLE, ST_FIN: begin
                if (accept) begin
                    remain_d = xfer_len;
                    state_d  = (xfer_len == '0) ? ST_DRAIN : ST_SEND;
                end
            end
            ST_SEND: begin
                if (strobe) begin
                    remain_d = remain_q - LEN_W'(1);
                    if (remain_q == LEN_W'(1)) begin
                        state_d = ST_DRAIN;
                    end
                end
            end
            ST_DRAIN: begin
                if (cnt_zero) begin
                    state_d = ST_FIN;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            remain_q <= '0;
        end else begin
            state_q  <= state_d;
            remain_q <= remain_d;
        end
    end

    always_comb begin
        strobe = 1'b0;
        done   = 1'b0;
        unique case (state_q)
            ST_SEND:  strobe = send_req && space_ok && pace_ready;
            ST_FIN:   done   = 1'b1;
            default: ;
        endcase
    end

    // R7: no strobe is issued with nothing left to send
    a_r7_no_excess: assert property (@(posedge clk) disable iff (!rst_n)
        strobe |-> (remain_q != '0));
endmodule

// File: rtl/sxfer_window.sv
module sxfer_window #(
    parameter int WIN_SMALL = 8,
    parameter int WIN_LARGE = 16,
    parameter int LEN_W     = 16,
    parameter int PER_W     = 8,
    localparam int CNT_W    = $clog2(WIN_LARGE + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [LEN_W-1:0] xfer_len,
    input  logic             win_sel,
    input  logic [PER_W-1:0] period,
    input  logic             send_req,
    input  logic             ack_in,
    output logic             strobe,
    output logic [CNT_W-1:0] outstanding,
    output logic             win_full,
    output logic             done,
    output logic             proto_err
);
    logic space_ok;
    logic pace_ready;
    logic fire;

    sxw_seq #(.LEN_W(LEN_W)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .xfer_len   (xfer_len),
        .send_req   (send_req),
        .space_ok   (space_ok),
        .pace_ready (pace_ready),
        .cnt_zero   (outstanding == '0),
        .strobe     (fire),
        .done       (done)
    );

    sxw_pacer #(.PER_W(PER_W)) u_pacer (
        .clk    (clk),
        .rst_n  (rst_n),
        .period (period),
        .fire   (fire),
        .ready  (pace_ready)
    );

    sxw_credit #(
        .WIN_SMALL (WIN_SMALL),
        .WIN_LARGE (WIN_LARGE),
        .CNT_W     (CNT_W)
    ) u_credit (
        .clk       (clk),
        .rst_n     (rst_n),
        .win_sel   (win_sel),
        .fire      (fire),
        .ack       (ack_in),
        .cnt       (outstanding),
        .space_ok  (space_ok),
        .full      (win_full),
        .proto_err (proto_err)
    );

    assign strobe = fire;

    // R2: a strobe is never issued into a full window
    a_r2_space: assert property (@(posedge clk) disable iff (!rst_n)
        strobe |-> !win_full);
    // R8: done is only shown with the buffer drained
    a_r8_done_clean: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (outstanding == '0));
endmodule

// File: tb/sxfer_window_bench.sv
module sxfer_window_bench;
    localparam int LEN_W = 16;
    localparam int PER_W = 8;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             start = 1'b0;
    logic [LEN_W-1:0] xfer_len = '0;
    logic             win_sel = 1'b0;
    logic [PER_W-1:0] period = PER_W'(1);
    logic             send_req = 1'b0;
    logic             ack_in = 1'b0;
    logic             strobe;
    logic [4:0]       outstanding;
    logic             win_full;
    logic             done;
    logic             proto_err;

    always #10 clk = ~clk;

    sxfer_window u_sxfer_window (
        .clk(clk), .rst_n(rst_n), .start(start), .xfer_len(xfer_len),
        .win_sel(win_sel), .period(period), .send_req(send_req),
        .ack_in(ack_in), .strobe(strobe), .outstanding(outstanding),
        .win_full(win_full), .done(done), .proto_err(proto_err)
    );

    int n_chk = 0;
    int n_fail = 0;
    int m_cnt = 0, m_len = 0, m_sent = 0, stb_total = 0;
    bit m_win = 0, m_err = 0, m_busy = 0;
    longint cyc_no = 0, last_stb = -1000;
    int last_need = 1;

    function automatic int wsize(bit w);
        return w ? 16 : 8;
    endfunction

    task automatic check(bit ok, string req, string what, int act, int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic cyc();
        bit s, a;
        #1;
        check(outstanding == m_cnt, "R2", "outstanding", outstanding, m_cnt);
        check(win_full == (m_cnt >= wsize(m_win)), "R9", "win_full", win_full, m_cnt >= wsize(m_win));
        check(proto_err == m_err, "R4", "proto_err", proto_err, m_err);
        if (done) begin
            check(m_cnt == 0 && m_sent == m_len, "R8", "done early (sent)", m_sent, m_len);
            m_busy = 0;
        end
        s = strobe;
        a = ack_in;
        if (s) begin
            check(m_cnt < wsize(m_win), "R2", "strobe into full window", m_cnt, wsize(m_win));
            check(m_busy && m_sent < m_len, "R7", "excess strobe (sent)", m_sent, m_len);
            check(cyc_no - last_stb >= last_need, "R5", "strobe spacing", int'(cyc_no - last_stb), last_need);
            last_stb = cyc_no;
            last_need = (period > 1) ? int'(period) : 1;
            m_sent++;
            stb_total++;
        end
        if (start && !m_busy) begin
            m_len = int'(xfer_len);
            m_sent = 0;
            m_busy = 1;
        end
        if (m_cnt == 0) m_win = win_sel;
        if (a && m_cnt == 0) m_err = 1;
        m_cnt = m_cnt + int'(s) - int'(a && m_cnt > 0);
        @(posedge clk);
        #5;
        cyc_no++;
    endtask

    // mode 0: ack whenever something is in flight, data always offered
    // mode 1: random ack, random data offer, random window request
    task automatic run_until_done(int limit, int mode);
        for (int i = 0; i < limit; i++) begin
            if (done && !m_busy) break;
            if (mode == 0) begin
                send_req = 1;
                ack_in = (m_cnt > 0);
            end else begin
                send_req = ($urandom % 4) != 0;
                ack_in = (m_cnt > 0) && ($urandom % 2 == 0);
                win_sel = $urandom % 2;
            end
            cyc();
        end
        ack_in = 0;
        check(done, "R8", "done after drain", done, 1);
    endtask

    task automatic begin_xfer(int len);
        start = 1;
        xfer_len = LEN_W'(len);
        cyc();
        start = 0;
    endtask

    initial begin
        #(20 * 150000);
        n_fail++;
        $display("FAIL R8 watchdog expired: actual 0 expected 1");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        int base;
        longint prev;
        void'($urandom(32'h5C5100));
        send_req = 1;
        repeat (3) @(posedge clk);
        #5;
        // R1: reset state
        check(outstanding == 0, "R1", "reset outstanding", outstanding, 0);
        check(!strobe && !done && !win_full && !proto_err, "R1", "reset flags",
              {strobe, done, win_full, proto_err}, 0);
        rst_n = 1;
        send_req = 0;

        // Small window fills at 8; a window change while full is ignored (R2, R6, R9)
        win_sel = 0; period = 1; send_req = 1; ack_in = 0;
        base = stb_total;
        begin_xfer(20);
        repeat (25) cyc();
        check(stb_total - base == 8, "R2", "strobes into 8-window", stb_total - base, 8);
        check(win_full && outstanding == 8, "R9", "full at 8", outstanding, 8);
        win_sel = 1;
        start = 1; xfer_len = 3;   // R7: ignored while busy
        repeat (4) cyc();
        start = 0;
        check(stb_total - base == 8, "R6", "window change while busy", stb_total - base, 8);
        run_until_done(200, 0);    // R3: coincident strobe and ack keep count
        check(stb_total - base == 20, "R7", "strobes for length 20", stb_total - base, 20);

        // Large window adopted after drain (R6)
        ack_in = 0; send_req = 1;
        base = stb_total;
        begin_xfer(20);
        repeat (25) cyc();
        check(stb_total - base == 16, "R6", "strobes into 16-window", stb_total - base, 16);
        check(win_full && outstanding == 16, "R9", "full at 16", outstanding, 16);
        run_until_done(200, 0);

        // Paced strobes exactly period apart (R5)
        period = 4;
        base = stb_total;
        prev = -1;
        start = 1; xfer_len = 5; send_req = 1; ack_in = 0;
        for (int i = 0; i < 40; i++) begin
            #1;
            if (strobe) begin
                if (prev >= 0)
                    check(cyc_no - prev == 4, "R5", "paced gap", int'(cyc_no - prev), 4);
                prev = cyc_no;
            end
            cyc();
            start = 0;
            ack_in = (m_cnt > 0);
        end
        check(stb_total - base == 5, "R7", "paced length", stb_total - base, 5);
        run_until_done(50, 0);

        // Zero length: no strobe, done again (R7, R8)
        period = 0;
        base = stb_total;
        begin_xfer(0);
        run_until_done(20, 0);
        check(stb_total - base == 0, "R7", "zero length strobes", stb_total - base, 0);

        // Random transfers
        for (int t = 0; t < 12; t++) begin
            int len;
            len = 1 + ($urandom % 40);
            period = PER_W'($urandom % 4);
            base = stb_total;
            begin_xfer(len);
            run_until_done(3000, 1);
            check(stb_total - base == len, "R7", "random length", stb_total - base, len);
        end

        // Acknowledge with nothing in flight (R4)
        send_req = 0;
        ack_in = 1;
        cyc();
        ack_in = 0;
        cyc();
        check(proto_err == 1, "R4", "error latched", proto_err, 1);
        check(outstanding == 0, "R4", "no underflow", outstanding, 0);
        repeat (3) cyc();
        check(proto_err == 1, "R4", "error sticky", proto_err, 1);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule